// File: doc/BRIEF.md
# Clock Source Failover Controller

This block decides which source drives the system clock of a microcontroller-style clock module, and when the internal reset is asserted or released. There are three sources. The first is an external input divided by two. The second is a reference path. The third is a PLL, which is either locked or running free in self-clocked mode. The analog PLL and the clock edges are not modelled. Their condition arrives as status flags: external clock running, reference valid, PLL locked, self-clocked mode available and loss-of-clock failure.

After a power-on reset the controller takes one of two roles, chosen by a mode pin. In external mode it reports a halted state until the external clock runs. It recognises reset requests only after that. In PLL mode it boots on the self-clocked PLL and holds reset until the reference is valid and the PLL has locked. A loss-of-clock failure in the locked state makes the controller enter reset on the reference path for a fixed window. It then moves to self-clocked mode if that mode works. If self-clocked mode does not work, or if loss-of-clock handling is disabled, the controller halts. Only a power-on reset clears the halted state.

Top module: `clk_failover_ctrl`

## Requirements
- R1: A cycle with `rst_n` low selects the start state from `mode_pll`. With PLL mode this gives `src_sel`=10, `halted`=0, `sys_rst`=1. With external mode it gives `src_sel`=00, `halted`=1, `sys_rst`=1. Source codes are: 00 external divided by two, 01 reference, 10 PLL self-clocked, 11 PLL locked.
- R2: In external mode, while `ext_clk_run` is low, the outputs stay at halted (00, `halted`=1, `sys_rst`=1) and `rst_req` has no effect. Once the clock runs with no request, the outputs become 00, `halted`=0, `sys_rst`=0.
- R3: In external mode with the clock running, `rst_req` high asserts `sys_rst` one cycle later. `sys_rst` drops one cycle after `rst_req` falls. If `ext_clk_run` falls, the block returns to the halted condition of R2.
- R4: In the PLL boot state the output is 10 with `sys_rst`=1. It changes to 11 with `sys_rst`=0 in the cycle after `ref_ok`, `pll_lock` are high and `rst_req` is low together.
- R5: In the locked state, `loc_fail` with `loc_en` high moves the block to source 01 with `sys_rst`=1 for exactly `HOLD_CYC` cycles (4 by default).
- R6: At the end of that window, if `scm_ok` is high, the block goes to the PLL boot state (10, `sys_rst`=1) and then follows R4.
- R7: At the end of that window, if `scm_ok` is low, the block halts: `src_sel`=01, `halted`=1, `sys_rst`=1.
- R8: In the locked state, `loc_fail` with `loc_en` low halts the block in the next cycle.
- R9: In the locked state, `rst_req` returns the block to the PLL boot state only when `scm_ok` is high. Otherwise the request is ignored and the output stays 11 with `sys_rst`=0.
- R10: The halted state after a failure ignores every input except `rst_n`.
- R11: In the locked state, `loc_fail` takes priority over `rst_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| mode_pll | input | 1 | 1 selects PLL mode, 0 selects external mode; sampled during reset |
| ext_clk_run | input | 1 | External clock is toggling |
| ref_ok | input | 1 | Reference input is within limits |
| pll_lock | input | 1 | PLL has achieved lock |
| scm_ok | input | 1 | Self-clocked mode is functional |
| loc_fail | input | 1 | Loss-of-clock failure detected |
| loc_en | input | 1 | Loss-of-clock failover enabled |
| rst_req | input | 1 | External reset request |
| src_sel | output | 2 | Selected clock source code |
| halted | output | 1 | Clocks are static |
| sys_rst | output | 1 | Internal reset to the rest of the chip |

## Verification
The hardest situation to reach is the end of the reference-reset window. At that point the value of `scm_ok` in the single exit cycle decides between failover and halt. The stimulus first drives the block to lock, then pulses `loc_fail` and holds `scm_ok` at a chosen value across the whole window. Every cycle of the window is checked so that an off-by-one window length is caught. The halted state is then hit with every other input toggling, to show that only `rst_n` leaves it.

// File: rtl/cfc_pkg.sv
// Shared types for the clock source failover controller.
// Assumes a 2-bit source code; state encoding is private to the block.
package cfc_pkg;
    localparam int SRC_W = 2;

    localparam logic [SRC_W-1:0] SRC_EXT  = 2'b00;
    localparam logic [SRC_W-1:0] SRC_REF  = 2'b01;
    localparam logic [SRC_W-1:0] SRC_SCM  = 2'b10;
    localparam logic [SRC_W-1:0] SRC_LOCK = 2'b11;

    typedef enum logic [2:0] {
        ST_EXT_WAIT = 3'd0,
        ST_EXT_RUN  = 3'd1,
        ST_EXT_RST  = 3'd2,
        ST_BOOT     = 3'd3,
        ST_LOCK     = 3'd4,
        ST_FAIL_REF = 3'd5,
        ST_HALT     = 3'd6
    } cfc_state_e;
endpackage

// File: rtl/cfc_hold_timer.sv
// Counts the cycles spent entering reset on the reference path.
// Assumes HOLD_CYC >= 2; the count restarts whenever the window is left.
module cfc_hold_timer #(
    parameter int HOLD_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_window,
    output logic done
);
    localparam int CNT_W = $clog2(HOLD_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    // Advance inside the window, clear outside it.
    always_ff @(posedge clk) begin
        if (!rst_n || !in_window) cnt_q <= '0;
        else if (cnt_q != LAST)   cnt_q <= cnt_q + 1'b1;
    end

    assign done = in_window && (cnt_q == LAST);

    // R5: the count never passes the last window cycle.
    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
    // R5: leaving the window restarts the count.
    assert_cnt_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_window |=> cnt_q == '0);
endmodule

// File: rtl/cfc_next_state.sv
// Next-state logic of the failover controller.
// Assumes the status flags are already synchronous to clk.
module cfc_next_state
    import cfc_pkg::*;
(
    input  cfc_state_e state_q,
    input  logic       ext_clk_run,
    input  logic       ref_ok,
    input  logic       pll_lock,
    input  logic       scm_ok,
    input  logic       loc_fail,
    input  logic       loc_en,
    input  logic       rst_req,
    input  logic       hold_done,
    output cfc_state_e state_d
);
    // Select the following state from the current one and the flags.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EXT_WAIT: if (ext_clk_run) state_d = rst_req ? ST_EXT_RST : ST_EXT_RUN;
            ST_EXT_RUN: begin
                if (!ext_clk_run) state_d = ST_EXT_WAIT;
                else if (rst_req) state_d = ST_EXT_RST;
            end
            ST_EXT_RST: begin
                if (!ext_clk_run) state_d = ST_EXT_WAIT;
                else if (!rst_req) state_d = ST_EXT_RUN;
            end
            ST_BOOT: if (ref_ok && pll_lock && !rst_req) state_d = ST_LOCK;
            ST_LOCK: begin
                if (loc_fail)                state_d = loc_en ? ST_FAIL_REF : ST_HALT;
                else if (rst_req && scm_ok)  state_d = ST_BOOT;
            end
            ST_FAIL_REF: if (hold_done) state_d = scm_ok ? ST_BOOT : ST_HALT;
            ST_HALT: state_d = ST_HALT;
            default: state_d = ST_HALT;
        endcase
    end
endmodule

// File: rtl/cfc_out_decode.sv
// Maps the controller state to source code, halt flag and reset.
// Assumes outputs follow the registered state with no extra delay.
module cfc_out_decode
    import cfc_pkg::*;
(
    input  cfc_state_e       state_q,
    output logic [SRC_W-1:0] src_sel,
    output logic             halted,
    output logic             sys_rst
);
    // Decode the outputs of each state.
    always_comb begin
        src_sel = SRC_REF;
        halted  = 1'b1;
        sys_rst = 1'b1;
        unique case (state_q)
            ST_EXT_WAIT: begin src_sel = SRC_EXT;  halted = 1'b1; sys_rst = 1'b1; end
            ST_EXT_RUN:  begin src_sel = SRC_EXT;  halted = 1'b0; sys_rst = 1'b0; end
            ST_EXT_RST:  begin src_sel = SRC_EXT;  halted = 1'b0; sys_rst = 1'b1; end
            ST_BOOT:     begin src_sel = SRC_SCM;  halted = 1'b0; sys_rst = 1'b1; end
            ST_LOCK:     begin src_sel = SRC_LOCK; halted = 1'b0; sys_rst = 1'b0; end
            ST_FAIL_REF: begin src_sel = SRC_REF;  halted = 1'b0; sys_rst = 1'b1; end
            ST_HALT:     begin src_sel = SRC_REF;  halted = 1'b1; sys_rst = 1'b1; end
            default:     begin src_sel = SRC_REF;  halted = 1'b1; sys_rst = 1'b1; end
        endcase
    end
endmodule

// File: rtl/clk_failover_ctrl.sv
// Top of the clock source failover controller: state register plus
// next-state, hold-window timer and output decode. Assumes mode_pll is
// stable while rst_n is low; it is read only then.
module clk_failover_ctrl
    import cfc_pkg::*;
#(
    parameter int HOLD_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_pll,
    input  logic             ext_clk_run,
    input  logic             ref_ok,
    input  logic             pll_lock,
    input  logic             scm_ok,
    input  logic             loc_fail,
    input  logic             loc_en,
    input  logic             rst_req,
    output logic [SRC_W-1:0] src_sel,
    output logic             halted,
    output logic             sys_rst
);
    cfc_state_e state_q, state_d;
    logic       hold_done;

    // Hold the controller state; the power-on reset picks the mode.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= mode_pll ? ST_BOOT : ST_EXT_WAIT;
        else        state_q <= state_d;
    end

    cfc_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_window (state_q == ST_FAIL_REF),
        .done      (hold_done)
    );

    cfc_next_state u_next (
        .state_q     (state_q),
        .ext_clk_run (ext_clk_run),
        .ref_ok      (ref_ok),
        .pll_lock    (pll_lock),
        .scm_ok      (scm_ok),
        .loc_fail    (loc_fail),
        .loc_en      (loc_en),
        .rst_req     (rst_req),
        .hold_done   (hold_done),
        .state_d     (state_d)
    );

    cfc_out_decode u_dec (
        .state_q (state_q),
        .src_sel (src_sel),
        .halted  (halted),
        .sys_rst (sys_rst)
    );

    // R2: without a running external clock the block stays waiting.
    assert_ext_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXT_WAIT && !ext_clk_run) |=> halted && src_sel == SRC_EXT);
    // R4: lock is not reported before reference and lock are both seen.
    assert_boot_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BOOT && !(ref_ok && pll_lock)) |=> src_sel != SRC_LOCK);
    // R8: disabled failover halts right away.
    assert_loc_dis_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCK && loc_fail && !loc_en) |=> halted);
    // R9: a request without self-clocked mode leaves the PLL locked.
    assert_req_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCK && rst_req && !scm_ok && !loc_fail) |=> (src_sel == SRC_LOCK && !sys_rst));
    // R10: the halted state is held until power-on reset.
    assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT) |=> halted && sys_rst);
    // R11: a failure wins over a reset request.
    assert_fail_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCK && loc_fail && loc_en) |=> src_sel == SRC_REF);
endmodule

// File: tb/sim_clk_failover_ctrl.sv
module sim_clk_failover_ctrl;
    localparam int HOLD = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0, mode_pll = 1'b1, ext_clk_run = 1'b0, ref_ok = 1'b0;
    logic pll_lock = 1'b0, scm_ok = 1'b1, loc_fail = 1'b0, loc_en = 1'b1, rst_req = 1'b0;
    logic [1:0] src_sel;
    logic halted, sys_rst;
    int errors = 0, checks = 0, cyc = 0;

    always #2 clk = ~clk;

    clk_failover_ctrl #(.HOLD_CYC(HOLD)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_pll(mode_pll), .ext_clk_run(ext_clk_run),
        .ref_ok(ref_ok), .pll_lock(pll_lock), .scm_ok(scm_ok), .loc_fail(loc_fail),
        .loc_en(loc_en), .rst_req(rst_req), .src_sel(src_sel), .halted(halted),
        .sys_rst(sys_rst));

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(string req, logic [1:0] es, logic eh, logic er);
        checks++;
        if (src_sel !== es || halted !== eh || sys_rst !== er) begin
            errors++;
            $display("FAIL %s: got src=%b halt=%b rst=%b, expected src=%b halt=%b rst=%b",
                     req, src_sel, halted, sys_rst, es, eh, er);
        end
    endtask

    task automatic por(logic pll);
        mode_pll = pll; rst_n = 1'b0; loc_fail = 1'b0; rst_req = 1'b0;
        step();
        rst_n = 1'b1;
    endtask

    task automatic to_lock();
        por(1'b1); ref_ok = 1'b1; pll_lock = 1'b1; loc_en = 1'b1; scm_ok = 1'b1;
        step();
        chk("R4 reach lock", 2'b11, 1'b0, 1'b0);
    endtask

    task automatic t_ext();
        por(1'b0);
        chk("R1 external start", 2'b00, 1'b1, 1'b1);
        rst_req = 1'b1; step(3);
        chk("R2 request ignored while static", 2'b00, 1'b1, 1'b1);
        rst_req = 1'b0; ext_clk_run = 1'b1; step();
        chk("R2 clock running", 2'b00, 1'b0, 1'b0);
        rst_req = 1'b1; step();
        chk("R3 request honoured", 2'b00, 1'b0, 1'b1);
        rst_req = 1'b0; step();
        chk("R3 request released", 2'b00, 1'b0, 1'b0);
        ext_clk_run = 1'b0; step();
        chk("R3 clock lost", 2'b00, 1'b1, 1'b1);
    endtask

    task automatic t_boot();
        ref_ok = 1'b0; pll_lock = 1'b0;
        por(1'b1);
        chk("R1 PLL start", 2'b10, 1'b0, 1'b1);
        ref_ok = 1'b1; step(2);
        chk("R4 reference only", 2'b10, 1'b0, 1'b1);
        pll_lock = 1'b1; rst_req = 1'b1; step();
        chk("R4 held by request", 2'b10, 1'b0, 1'b1);
        rst_req = 1'b0; step();
        chk("R4 locked", 2'b11, 1'b0, 1'b0);
    endtask

    task automatic t_failover_scm();
        to_lock();
        loc_fail = 1'b1; step(); loc_fail = 1'b0;
        for (int i = 0; i < HOLD; i++) begin
            chk("R5 reference reset window", 2'b01, 1'b0, 1'b1);
            step();
        end
        chk("R6 to self-clocked", 2'b10, 1'b0, 1'b1);
        step();
        chk("R6 relock", 2'b11, 1'b0, 1'b0);
    endtask

    task automatic t_failover_halt();
        to_lock();
        scm_ok = 1'b0; loc_fail = 1'b1; step(); loc_fail = 1'b0;
        step(HOLD - 1);
        chk("R5 last window cycle", 2'b01, 1'b0, 1'b1);
        step();
        chk("R7 halt without self-clocked", 2'b01, 1'b1, 1'b1);
        scm_ok = 1'b1; rst_req = 1'b1; ext_clk_run = 1'b1; loc_fail = 1'b1; step(2);
        rst_req = 1'b0; loc_fail = 1'b0; ref_ok = 1'b0; step(2);
        chk("R10 halt sticky", 2'b01, 1'b1, 1'b1);
        ref_ok = 1'b1; ext_clk_run = 1'b0;
        por(1'b1); step();
        chk("R10 cleared by power-on", 2'b11, 1'b0, 1'b0);
    endtask

    task automatic t_loc_disabled();
        to_lock();
        loc_en = 1'b0; loc_fail = 1'b1; step(); loc_fail = 1'b0;
        chk("R8 disabled failover halts", 2'b01, 1'b1, 1'b1);
        loc_en = 1'b1;
    endtask

    task automatic t_rst_req();
        to_lock();
        scm_ok = 1'b0; rst_req = 1'b1; step(2);
        chk("R9 request ignored", 2'b11, 1'b0, 1'b0);
        scm_ok = 1'b1; step();
        chk("R9 request honoured", 2'b10, 1'b0, 1'b1);
        rst_req = 1'b0; step();
        chk("R9 relock after request", 2'b11, 1'b0, 1'b0);
    endtask

    task automatic t_priority();
        to_lock();
        rst_req = 1'b1; loc_fail = 1'b1; step();
        rst_req = 1'b0; loc_fail = 1'b0;
        chk("R11 failure before request", 2'b01, 1'b0, 1'b1);
    endtask

    initial begin
        step(2);
        t_ext();
        t_boot();
        t_failover_scm();
        t_failover_halt();
        t_loc_disabled();
        t_rst_req();
        t_priority();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule